// File: doc/BRIEF.md
# Received Frame Router

This block takes device-to-host frames from a link as a stream of 32-bit doublewords, marked with a start beat and an end beat, and places each well-formed frame into the port's receive area in memory. The first byte of the first doubleword carries the frame type. That byte selects the slot inside the area the frame is written to, and the length the frame must have. Bits 11:8 of the first doubleword carry the port-multiplier index.

The block holds a frame until its end beat arrives and checks the length before it writes anything. A good frame goes out as one wide write request. That request carries the doubleword count and the frame data, with doubleword 0 in the lowest 32 bits. A frame with a bad length, or of an unknown type, is not written and raises the unknown-frame flag instead.

Each frame kind has its own sticky status flag. Software clears a flag by writing a one to it, and an interrupt request is raised while any set flag is enabled. The receive area is either one 256-byte block, or a 4 KB region with one 256-byte sub-area for each port-multiplier index.

Top module: `rxfis_router`

## Requirements
- R1: After reset, memWrValid is 0, intStatus is all zero and intReq is 0.
- R2: A frame of type 41h that is exactly 7 doublewords long produces one write with memWrDwords = 7 and slot offset 00h. Doubleword k of the frame sits at memWrData[32k+31:32k]. The frame sets intStatus bit 2.
- R3: A frame of type 5Fh that is exactly 5 doublewords long produces one write with memWrDwords = 5 and slot offset 20h. Doublewords 5 and 6 of memWrData are zero. The frame sets intStatus bit 1.
- R4: A frame of type 34h that is exactly 5 doublewords long produces one write with memWrDwords = 5 and slot offset 40h. The frame sets intStatus bit 0.
- R5: A frame whose type byte is not 41h, 5Fh or 34h produces no write and sets intStatus bit 5.
- R6: A frame of a known type whose length differs from its type's length produces no write and sets intStatus bit 5. This includes frames longer than 7 doublewords.
- R7: With fbsEnable = 0, memWrAddr = {areaBase[ADDR_W-1:8], offset}. With fbsEnable = 1, memWrAddr = {areaBase[ADDR_W-1:12], pm, offset}, where pm is bits 11:8 of the frame's first doubleword.
- R8: Beats that arrive while rxEnable is 0 are discarded. A frame sent while rxEnable is 0 produces no write and changes no status flag.
- R9: A clrValid pulse clears every intStatus bit whose clrMask bit is 1, and leaves the other bits unchanged.
- R10: When a frame sets a status bit in the same cycle that clrValid clears that bit, the bit ends up set. Other bits in the clear mask are still cleared.
- R11: intReq is 1 exactly when some intStatus bit and the same intEnable bit are both 1.
- R12: The write request is valid for exactly one cycle, in the cycle after the clock edge that samples the end beat. The status flag for that frame appears in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| rxEnable | input | 1 | Receive gate; beats are discarded while low |
| fbsEnable | input | 1 | Selects the 4 KB area split by port-multiplier index |
| areaBase | input | ADDR_W | Base address of the receive area |
| inValid | input | 1 | Beat valid |
| inSof | input | 1 | First beat of a frame |
| inEof | input | 1 | Last beat of a frame |
| inData | input | 32 | Beat doubleword |
| intEnable | input | 8 | Interrupt enable per status bit |
| clrValid | input | 1 | Write-one-to-clear strobe |
| clrMask | input | 8 | Bits to clear |
| memWrValid | output | 1 | Write request valid |
| memWrAddr | output | ADDR_W | Byte address of the slot |
| memWrData | output | 224 | Frame data, doubleword 0 lowest |
| memWrDwords | output | 3 | Number of valid doublewords |
| intStatus | output | 8 | Sticky status flags |
| intReq | output | 1 | Interrupt request |

## Verification
The hardest case to reach from the ports is a clear that lands on the very edge where a frame's end beat sets the same flag. The driver task can place a clear mask on the end beat of any frame it sends, so the collision falls on an exact cycle. It covers both the bit being set and an unrelated bit in the same mask. Frames that run past the capture buffer, and frames cut short, drive the counter to its saturation limit and to its mismatch outcome. The scoreboard then confirms that nothing reaches memory.

// File: rtl/rxfis_pkg.sv
package rxfis_pkg;
  localparam int DW_BITS   = 32;
  localparam int MAX_BYTES = 28;
  localparam int MAX_DW    = MAX_BYTES / 4;
  localparam int IDX_W     = $clog2(MAX_DW);
  localparam int CNT_W     = $clog2(MAX_DW + 2);
  localparam int STAT_W    = 8;

  localparam logic [7:0] TYPE_DMA = 8'h41;
  localparam logic [7:0] TYPE_PIO = 8'h5F;
  localparam logic [7:0] TYPE_REG = 8'h34;

  localparam logic [7:0] OFS_DMA = 8'h00;
  localparam logic [7:0] OFS_PIO = 8'h20;
  localparam logic [7:0] OFS_REG = 8'h40;

  localparam int LEN_DMA   = 7;
  localparam int LEN_SHORT = 5;

  localparam int BIT_REG = 0;
  localparam int BIT_PIO = 1;
  localparam int BIT_DMA = 2;
  localparam int BIT_UNK = 5;

  typedef enum logic [1:0] {K_UNK, K_DMA, K_PIO, K_REG} kind_e;

  typedef struct packed {
    logic             beatWe;
    logic [IDX_W-1:0] beatIdx;
    logic             hdrWe;
    logic             commit;
    logic [7:0]       offset;
    logic [IDX_W-1:0] dwords;
  } strobe_t;

  function automatic kind_e decodeType(input logic [7:0] t);
    case (t)
      TYPE_DMA: decodeType = K_DMA;
      TYPE_PIO: decodeType = K_PIO;
      TYPE_REG: decodeType = K_REG;
      default:  decodeType = K_UNK;
    endcase
  endfunction
endpackage

// File: rtl/rxfis_ctrl.sv
module rxfis_ctrl
  import rxfis_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              rxEnable,
  input  logic              inValid,
  input  logic              inSof,
  input  logic              inEof,
  input  logic [7:0]        typeByte,
  input  logic              clrValid,
  input  logic [STAT_W-1:0] clrMask,
  output strobe_t           strb,
  output logic [STAT_W-1:0] status
);
  localparam logic [CNT_W-1:0] CNT_MAX = CNT_W'(MAX_DW + 1);

  logic              inFrame;
  logic [CNT_W-1:0]  cnt;
  kind_e             kindQ;

  logic              accept, inBeat, endBeat, goodEnd, badEnd;
  logic [CNT_W-1:0]  beatPos, beatLen, expLen;
  kind_e             curKind;
  logic [7:0]        slotOfs;
  logic [STAT_W-1:0] setMask, clrBits;

  always_comb begin
    accept  = inValid & rxEnable;
    inBeat  = accept & (inSof | inFrame);
    endBeat = inBeat & inEof;
    beatPos = inSof ? '0 : cnt;
    beatLen = beatPos + CNT_W'(1);
    curKind = inSof ? decodeType(typeByte) : kindQ;
    case (curKind)
      K_DMA:   begin expLen = CNT_W'(LEN_DMA);   slotOfs = OFS_DMA; end
      K_PIO:   begin expLen = CNT_W'(LEN_SHORT); slotOfs = OFS_PIO; end
      K_REG:   begin expLen = CNT_W'(LEN_SHORT); slotOfs = OFS_REG; end
      default: begin expLen = '0;                slotOfs = '0;      end
    endcase
    goodEnd = endBeat & (curKind != K_UNK) & (beatLen == expLen);
    badEnd  = endBeat & ~goodEnd;

    setMask = '0;
    if (goodEnd) begin
      case (curKind)
        K_DMA:   setMask[BIT_DMA] = 1'b1;
        K_PIO:   setMask[BIT_PIO] = 1'b1;
        default: setMask[BIT_REG] = 1'b1;
      endcase
    end
    if (badEnd) setMask[BIT_UNK] = 1'b1;
    clrBits = clrValid ? clrMask : '0;

    strb.beatWe  = inBeat & (beatPos < CNT_W'(MAX_DW));
    strb.beatIdx = beatPos[IDX_W-1:0];
    strb.hdrWe   = accept & inSof;
    strb.commit  = goodEnd;
    strb.offset  = slotOfs;
    strb.dwords  = expLen[IDX_W-1:0];
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      inFrame <= 1'b0;
      cnt     <= '0;
      kindQ   <= K_UNK;
      status  <= '0;
    end else begin
      // set after clear: a same-cycle set wins (R10)
      status <= (status & ~clrBits) | setMask;
      if (endBeat)         inFrame <= 1'b0;
      else if (strb.hdrWe) inFrame <= 1'b1;
      if (strb.hdrWe) kindQ <= decodeType(typeByte);
      if (inBeat) cnt <= (beatPos == CNT_MAX) ? beatPos : beatPos + CNT_W'(1);
    end
  end

  p_disabled_no_set_r8: assert property (@(posedge clk) disable iff (!rstN)
    !rxEnable |=> ((status & ~$past(status)) == '0));

  p_set_wins_r10: assert property (@(posedge clk) disable iff (!rstN)
    (setMask != '0) |=> ((status & $past(setMask)) == $past(setMask)));

  p_clear_r9: assert property (@(posedge clk) disable iff (!rstN)
    (clrValid && setMask == '0) |=> ((status & $past(clrMask)) == '0));
endmodule

// File: rtl/rxfis_dpath.sv
module rxfis_dpath
  import rxfis_pkg::*;
#(
  parameter int ADDR_W = 32
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  strobe_t                  strb,
  input  logic [DW_BITS-1:0]       inData,
  input  logic                     fbsEnable,
  input  logic [ADDR_W-1:0]        areaBase,
  output logic                     memWrValid,
  output logic [ADDR_W-1:0]        memWrAddr,
  output logic [MAX_DW*DW_BITS-1:0] memWrData,
  output logic [IDX_W-1:0]         memWrDwords
);
  logic [DW_BITS-1:0] bufQ [MAX_DW];
  logic [3:0]         pmQ;
  logic [ADDR_W-1:0]  alignedBase, slotAddr;

  always_comb begin
    if (fbsEnable) begin
      alignedBase = areaBase & ~ADDR_W'(12'hFFF);
      slotAddr    = alignedBase | ADDR_W'({pmQ, strb.offset});
    end else begin
      alignedBase = areaBase & ~ADDR_W'(8'hFF);
      slotAddr    = alignedBase | ADDR_W'(strb.offset);
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int i = 0; i < MAX_DW; i++) bufQ[i] <= '0;
      pmQ         <= '0;
      memWrValid  <= 1'b0;
      memWrAddr   <= '0;
      memWrDwords <= '0;
    end else begin
      if (strb.beatWe) bufQ[strb.beatIdx] <= inData;
      if (strb.hdrWe)  pmQ <= inData[11:8];
      memWrValid <= strb.commit;
      if (strb.commit) begin
        memWrAddr   <= slotAddr;
        memWrDwords <= strb.dwords;
      end
    end
  end

  for (genvar g = 0; g < MAX_DW; g++) begin : g_lane
    assign memWrData[g*DW_BITS +: DW_BITS] =
      (IDX_W'(g) < memWrDwords) ? bufQ[g] : '0;
  end

  p_len_legal_r6: assert property (@(posedge clk) disable iff (!rstN)
    memWrValid |-> (memWrDwords == IDX_W'(LEN_DMA) || memWrDwords == IDX_W'(LEN_SHORT)));

  p_slot_match_r2: assert property (@(posedge clk) disable iff (!rstN)
    memWrValid |-> ((memWrAddr[7:0] == OFS_DMA) == (memWrDwords == IDX_W'(LEN_DMA))));

  p_single_write_r12: assert property (@(posedge clk) disable iff (!rstN)
    memWrValid |=> !memWrValid);
endmodule

// File: rtl/rxfis_router.sv
module rxfis_router
  import rxfis_pkg::*;
#(
  parameter int ADDR_W = 32
) (
  input  logic                      clk,
  input  logic                      rstN,
  input  logic                      rxEnable,
  input  logic                      fbsEnable,
  input  logic [ADDR_W-1:0]         areaBase,
  input  logic                      inValid,
  input  logic                      inSof,
  input  logic                      inEof,
  input  logic [DW_BITS-1:0]        inData,
  input  logic [STAT_W-1:0]         intEnable,
  input  logic                      clrValid,
  input  logic [STAT_W-1:0]         clrMask,
  output logic                      memWrValid,
  output logic [ADDR_W-1:0]         memWrAddr,
  output logic [MAX_DW*DW_BITS-1:0] memWrData,
  output logic [IDX_W-1:0]          memWrDwords,
  output logic [STAT_W-1:0]         intStatus,
  output logic                      intReq
);
  strobe_t strb;

  rxfis_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .rxEnable(rxEnable),
    .inValid(inValid), .inSof(inSof), .inEof(inEof),
    .typeByte(inData[7:0]), .clrValid(clrValid), .clrMask(clrMask),
    .strb(strb), .status(intStatus)
  );

  rxfis_dpath #(.ADDR_W(ADDR_W)) u_dpath (
    .clk(clk), .rstN(rstN), .strb(strb), .inData(inData),
    .fbsEnable(fbsEnable), .areaBase(areaBase),
    .memWrValid(memWrValid), .memWrAddr(memWrAddr),
    .memWrData(memWrData), .memWrDwords(memWrDwords)
  );

  assign intReq = |(intStatus & intEnable);

  p_dma_flag_r2: assert property (@(posedge clk) disable iff (!rstN)
    (memWrValid && memWrDwords == IDX_W'(LEN_DMA)) |-> intStatus[BIT_DMA]);
endmodule

// File: tb/rxfis_router_tb.sv
`timescale 1ns/100ps
module rxfis_router_tb;
  logic         clk = 1'b0;
  logic         rstN = 1'b0;
  logic         rxEnable = 1'b0, fbsEnable = 1'b0;
  logic [31:0]  areaBase = 32'h8765_4300;
  logic         inValid = 1'b0, inSof = 1'b0, inEof = 1'b0;
  logic [31:0]  inData = '0;
  logic [7:0]   intEnable = '0;
  logic         clrValid = 1'b0;
  logic [7:0]   clrMask = '0;
  logic         memWrValid;
  logic [31:0]  memWrAddr;
  logic [223:0] memWrData;
  logic [2:0]   memWrDwords;
  logic [7:0]   intStatus;
  logic         intReq;

  rxfis_router u_dut (
    .clk(clk), .rstN(rstN), .rxEnable(rxEnable), .fbsEnable(fbsEnable),
    .areaBase(areaBase), .inValid(inValid), .inSof(inSof), .inEof(inEof),
    .inData(inData), .intEnable(intEnable), .clrValid(clrValid), .clrMask(clrMask),
    .memWrValid(memWrValid), .memWrAddr(memWrAddr), .memWrData(memWrData),
    .memWrDwords(memWrDwords), .intStatus(intStatus), .intReq(intReq)
  );

  always #2.5 clk = ~clk;

  typedef struct packed {
    logic [31:0]  addr;
    logic [2:0]   dw;
    logic [223:0] data;
    logic [31:0]  cyc;
  } exp_t;

  exp_t        expQ[$];
  int          checks = 0, fails = 0;
  int          cyc = 0;
  logic [7:0]  expStat = '0;
  bit          done = 1'b0;

  always @(posedge clk) cyc <= cyc + 1;

  task automatic check(input bit ok, input string tag, input logic [255:0] act, input logic [255:0] expv);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, expv);
    end
  endtask

  // scoreboard monitor
  always @(negedge clk) begin
    if (rstN && memWrValid) begin
      checks++;
      if (expQ.size() == 0) begin
        fails++;
        $display("FAIL R5 R6 R8 unexpected write actual addr=%h dw=%0d expected none", memWrAddr, memWrDwords);
      end else begin
        exp_t e;
        e = expQ.pop_front();
        if (e.addr != memWrAddr || e.dw != memWrDwords || e.data != memWrData || e.cyc != 32'(cyc)) begin
          fails++;
          $display("FAIL R2 R3 R4 R7 R12 write actual addr=%h dw=%0d cyc=%0d data=%h expected addr=%h dw=%0d cyc=%0d data=%h",
                   memWrAddr, memWrDwords, cyc, memWrData, e.addr, e.dw, e.cyc, e.data);
        end
      end
    end
  end

  task automatic sendFrame(input logic [7:0] ty, input logic [3:0] pm, input int ndw,
                           input logic [3:0] seed, input bit en, input logic [7:0] clrEnd,
                           input string tag);
    int          need;
    logic [7:0]  ofs;
    logic [7:0]  setB;
    bit          good;
    exp_t        e;
    logic [31:0] d;
    need = 0; ofs = 8'h00; setB = 8'h00;
    if (ty == 8'h41) begin need = 7; ofs = 8'h00; end
    else if (ty == 8'h5F) begin need = 5; ofs = 8'h20; end
    else if (ty == 8'h34) begin need = 5; ofs = 8'h40; end
    good = (need != 0) && (ndw == need);
    e.data = '0;
    rxEnable = en;
    for (int i = 0; i < ndw; i++) begin
      @(posedge clk); #1;
      d = (i == 0) ? {12'hABC, seed, 4'h6, pm, ty} : {4'hD, seed, 16'h1234, 8'(i)};
      if (i < 7) e.data[i*32 +: 32] = d;
      inValid = 1'b1; inSof = (i == 0); inEof = (i == ndw - 1); inData = d;
      if (i == ndw - 1) begin
        clrValid = (clrEnd != 0); clrMask = clrEnd;
        if (good && en) begin
          e.addr = fbsEnable ? {areaBase[31:12], pm, ofs} : {areaBase[31:8], ofs};
          e.dw   = 3'(need);
          e.cyc  = 32'(cyc + 1);
          expQ.push_back(e);
        end
      end
    end
    @(posedge clk); #1;
    inValid = 1'b0; inSof = 1'b0; inEof = 1'b0; clrValid = 1'b0; clrMask = '0;
    rxEnable = 1'b1;
    if (en) begin
      if (!good) setB = 8'h20;
      else if (ty == 8'h41) setB = 8'h04;
      else if (ty == 8'h5F) setB = 8'h02;
      else setB = 8'h01;
    end
    expStat = (expStat & ~clrEnd) | setB;
    @(negedge clk);
    check(intStatus == expStat, tag, 256'(intStatus), 256'(expStat));
  endtask

  task automatic clearBits(input logic [7:0] m);
    @(posedge clk); #1;
    clrValid = 1'b1; clrMask = m;
    @(posedge clk); #1;
    clrValid = 1'b0; clrMask = '0;
    expStat = expStat & ~m;
    @(negedge clk);
    check(intStatus == expStat, "R9 clear", 256'(intStatus), 256'(expStat));
  endtask

  task automatic finishUp();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired actual=running expected=done");
      finishUp();
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    check(!memWrValid, "R1 reset write", 256'(memWrValid), 256'(0));
    check(intStatus == 0, "R1 reset status", 256'(intStatus), 256'(0));
    check(!intReq, "R1 reset irq", 256'(intReq), 256'(0));
    @(posedge clk); #1;
    rstN = 1'b1; rxEnable = 1'b1;

    sendFrame(8'h41, 4'h3, 7, 4'h1, 1'b1, 8'h00, "R2 dma flag");
    sendFrame(8'h5F, 4'h2, 5, 4'h2, 1'b1, 8'h00, "R3 pio flag");
    sendFrame(8'h34, 4'h1, 5, 4'h3, 1'b1, 8'h00, "R4 reg flag");
    clearBits(8'hFF);
    sendFrame(8'h27, 4'h0, 5, 4'h4, 1'b1, 8'h00, "R5 unknown type");
    clearBits(8'h20);
    sendFrame(8'h41, 4'h0, 5, 4'h5, 1'b1, 8'h00, "R6 short dma");
    clearBits(8'h20);
    sendFrame(8'h34, 4'h0, 9, 4'h6, 1'b1, 8'h00, "R6 long reg");
    sendFrame(8'h5F, 4'h0, 4, 4'h7, 1'b1, 8'h00, "R6 short pio");

    @(posedge clk); #1; fbsEnable = 1'b1;
    sendFrame(8'h34, 4'hA, 5, 4'h8, 1'b1, 8'h00, "R7 fbs reg");
    sendFrame(8'h41, 4'hF, 7, 4'h9, 1'b1, 8'h00, "R7 fbs dma");
    @(posedge clk); #1; fbsEnable = 1'b0;

    sendFrame(8'h5F, 4'h0, 5, 4'hA, 1'b0, 8'h00, "R8 disabled pio");
    sendFrame(8'h27, 4'h0, 3, 4'hB, 1'b0, 8'h00, "R8 disabled unknown");

    @(posedge clk); #1; intEnable = 8'h02;
    @(negedge clk);
    check(intReq == |(expStat & 8'h02), "R11 masked irq", 256'(intReq), 256'(|(expStat & 8'h02)));
    @(posedge clk); #1; intEnable = 8'h04;
    @(negedge clk);
    check(intReq == |(expStat & 8'h04), "R11 enabled irq", 256'(intReq), 256'(|(expStat & 8'h04)));

    sendFrame(8'h5F, 4'h0, 5, 4'hC, 1'b1, 8'h03, "R10 set wins");
    sendFrame(8'h41, 4'h0, 7, 4'hD, 1'b1, 8'h24, "R10 set wins dma");
    @(posedge clk); #1; intEnable = 8'h01;
    @(negedge clk);
    check(intReq == |(expStat & 8'h01), "R11 cleared irq", 256'(intReq), 256'(|(expStat & 8'h01)));

    repeat (4) @(posedge clk);
    @(negedge clk);
    check(expQ.size() == 0, "R12 all writes seen", 256'(expQ.size()), 256'(0));
    done = 1'b1;
    finishUp();
  end
endmodule